// File: doc/BRIEF.md
# Microprogrammed Memory Self-Test Engine

This block is a small test sequencer for one embedded RAM. A test program of up to eight instruction words is written into a local program store. A start pulse then sets the engine running on its own. Each cycle it takes the instruction under its pointer and drives the RAM address, write data and read or write strobes from that instruction. It updates its address register, data register and pointer, and folds returned read data into a signature register. The engine never predicts what a read should return. A test passes when the final signature equals one obtained from a known-good run.

Every instruction holds five command fields: sequencing, address, data, access type and compression. A halt flag ends the program. The data commands can rotate and invert the full-width pattern, and the pointer can branch on address wrap or data wrap. A few words can therefore express blankets, read-before-write conversions, and marching or walking patterns. When the program ends, the engine waits one cycle for the last read to land, then raises done and holds the signature until the next start.

Top module: `mbist_engine`

## Requirements
- R1: A write on the program port (prog_we high) stores prog_word into entry prog_idx of an eight-entry store. Instruction bits are: [2:0] sequencing, [4:3] address command, [7:5] data command, [9:8] access type, [10] compress enable, [11] halt.
- R2: A start seen while idle or done clears the pointer, address, data register, rotation count, signature and done. The instruction at entry 0 drives the RAM in the cycle after start is sampled.
- R3: In every executing cycle, ram_addr shows the address register and ram_wdata shows the data register. Access type 1 raises ram_re, 2 raises ram_we, and 0 or 3 raise neither. The two strobes are never high together.
- R4: Address command 0 or 3 holds the address and 2 clears it to 0. Command 1 increments it, wrapping from the top address to 0. That wrap is the address overflow.
- R5: Data commands act on the whole word: 0 hold, 1 all zeros, 2 invert, 3 rotate left by one, 4 rotate left then invert, 5 load a single one in bit 0, 6 and 7 hold. Commands 1 and 5 also clear the rotation count.
- R6: Commands 3 and 4 count rotations modulo the data width. The rotation that brings the count back to zero (the DATA_W-th since it was cleared) is the data overflow.
- R7: Sequencing codes: 0 always advances. 1 stays until address overflow, then advances. 2 advances on address overflow and otherwise steps the pointer back by one, holding at entry 0. 3 is the same as 2 on data overflow. 4 stays until data overflow, then advances. 5 to 7 advance.
- R8: Reaching an instruction with the halt flag set ends the program without any RAM access. Advancing beyond entry 7 also ends it. After the final step there is one drain cycle with no access, then done.
- R9: For a read with compress enabled, the data on ram_rdata one cycle later is folded in as sig = (sig << 1) ^ (sig[MSB] ? MISR_POLY : 0) ^ ram_rdata. MISR_POLY defaults to 8'h1D.
- R10: done rises in the cycle after the drain cycle. It stays high, with a steady signature and no RAM access, until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_we | input | 1 | Program store write strobe |
| prog_idx | input | 3 | Program store entry to write |
| prog_word | input | 12 | Instruction word to store |
| start | input | 1 | Begin execution from entry 0 |
| ram_addr | output | 4 | Address to the RAM under test |
| ram_wdata | output | 8 | Write data to the RAM under test |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe |
| ram_rdata | input | 8 | RAM read data, one cycle after ram_re |
| done | output | 1 | Program finished, signature valid |
| signature | output | 8 | Compressed read signature |

## Verification
The hardest situations to reach are the back-branch loops. In one, a data overflow must fall on a rotation made by the second instruction of a two-word loop. In another, a step-back must hold at entry 0 for a full address sweep. No single instruction reaches either case. The stimulus therefore loads whole programs built for these cases: a rotate-invert/rotate pair looped until the eighth rotation, and an invert-write at entry 0 that branches back onto itself. A reference interpreter in the bench, written from the field encodings, predicts the signature and run length. The bench RAM contents are then inspected for the walking-one and alternating patterns.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

    localparam int INSTR_W = 12;

    // sequencing codes
    localparam logic [2:0] SQ_NEXT   = 3'd0;
    localparam logic [2:0] SQ_LOOP_A = 3'd1;
    localparam logic [2:0] SQ_BR_A   = 3'd2;
    localparam logic [2:0] SQ_BR_D   = 3'd3;
    localparam logic [2:0] SQ_LOOP_D = 3'd4;

    // address commands
    localparam logic [1:0] AC_HOLD = 2'd0;
    localparam logic [1:0] AC_INC  = 2'd1;
    localparam logic [1:0] AC_CLR  = 2'd2;

    // data commands
    localparam logic [2:0] DC_HOLD = 3'd0;
    localparam logic [2:0] DC_ZERO = 3'd1;
    localparam logic [2:0] DC_INV  = 3'd2;
    localparam logic [2:0] DC_ROT  = 3'd3;
    localparam logic [2:0] DC_RINV = 3'd4;
    localparam logic [2:0] DC_ONE  = 3'd5;

    // access types
    localparam logic [1:0] RW_IDLE = 2'd0;
    localparam logic [1:0] RW_RD   = 2'd1;
    localparam logic [1:0] RW_WR   = 2'd2;

    typedef struct packed {
        logic       halt;
        logic       cmp;
        logic [1:0] rw;
        logic [2:0] dcmd;
        logic [1:0] acmd;
        logic [2:0] seq;
    } instr_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_DONE  = 2'd3
    } state_e;

endpackage

// File: rtl/mbist_ustore.sv
module mbist_ustore #(
    parameter int DEPTH = 8,
    parameter int IW    = 12,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [PTR_W-1:0] widx,
    input  logic [IW-1:0]    wdata,
    input  logic [PTR_W-1:0] ridx,
    output logic [IW-1:0]    rdata
);

    logic [IW-1:0] word_q [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q[e] <= '0;
            end else if (we && widx == PTR_W'(e)) begin
                word_q[e] <= wdata;
            end
        end
    end

    assign rdata = word_q[ridx];

endmodule

// File: rtl/mbist_data_gen.sv
module mbist_data_gen
    import mbist_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic [2:0]        cmd,
    output logic [DATA_W-1:0] data_q,
    output logic              ovf
);

    typedef struct packed {
        logic [DATA_W-1:0] pat;
        logic [CNT_W-1:0]  cnt;
    } dreg_t;

    dreg_t q, d;
    logic  rot_op;
    logic  cnt_top;

    always_comb begin
        d       = q;
        rot_op  = step && (cmd == DC_ROT || cmd == DC_RINV);
        cnt_top = (q.cnt == CNT_W'(DATA_W - 1));
        ovf     = rot_op && cnt_top;
        if (clear) begin
            d.pat = '0;
            d.cnt = '0;
        end else if (step) begin
            case (cmd)
                DC_ZERO: begin
                    d.pat = '0;
                    d.cnt = '0;
                end
                DC_INV:  d.pat = ~q.pat;
                DC_ROT:  d.pat = {q.pat[DATA_W-2:0], q.pat[DATA_W-1]};
                DC_RINV: d.pat = ~{q.pat[DATA_W-2:0], q.pat[DATA_W-1]};
                DC_ONE: begin
                    d.pat = DATA_W'(1);
                    d.cnt = '0;
                end
                default: ;
            endcase
            if (rot_op) begin
                d.cnt = cnt_top ? '0 : q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign data_q = q.pat;

endmodule

// File: rtl/mbist_misr.sv
module mbist_misr #(
    parameter int                W    = 8,
    parameter logic [W-1:0]      POLY = 'h1D
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] sig_q
);

    logic [W-1:0] sig_d;

    always_comb begin
        sig_d = sig_q;
        if (clear) begin
            sig_d = '0;
        end else if (en) begin
            sig_d = {sig_q[W-2:0], 1'b0} ^ (sig_q[W-1] ? POLY : '0) ^ din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= '0;
        else        sig_q <= sig_d;
    end

endmodule

// File: rtl/mbist_engine.sv
module mbist_engine
    import mbist_pkg::*;
#(
    parameter int                  DATA_W     = 8,
    parameter int                  ADDR_W     = 4,
    parameter int                  PROG_DEPTH = 8,
    parameter logic [DATA_W-1:0]   MISR_POLY  = 'h1D,
    localparam int                 PTR_W      = $clog2(PROG_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_we,
    input  logic [PTR_W-1:0]  prog_idx,
    input  logic [INSTR_W-1:0] prog_word,
    input  logic              start,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              ram_we,
    output logic              ram_re,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              done,
    output logic [DATA_W-1:0] signature
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(PROG_DEPTH - 1);

    typedef struct packed {
        state_e            state;
        logic [PTR_W-1:0]  ptr;
        logic [ADDR_W-1:0] addr;
        logic              pend;
    } seq_t;

    seq_t                q, d;
    logic [INSTR_W-1:0]  ins_raw;
    instr_t              ins;
    logic                accept, run_ex, a_ovf, d_ovf, adv, dec;
    logic [DATA_W-1:0]   data_q;

    mbist_ustore #(.DEPTH(PROG_DEPTH), .IW(INSTR_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (prog_we),
        .widx  (prog_idx),
        .wdata (prog_word),
        .ridx  (q.ptr),
        .rdata (ins_raw)
    );

    assign ins = instr_t'(ins_raw);

    mbist_data_gen #(.DATA_W(DATA_W)) u_data (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (accept),
        .step   (run_ex),
        .cmd    (ins.dcmd),
        .data_q (data_q),
        .ovf    (d_ovf)
    );

    mbist_misr #(.W(DATA_W), .POLY(MISR_POLY)) u_misr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .en    (q.pend),
        .din   (ram_rdata),
        .sig_q (signature)
    );

    always_comb begin
        d      = q;
        accept = start && (q.state == ST_IDLE || q.state == ST_DONE);
        run_ex = (q.state == ST_RUN) && !ins.halt;
        a_ovf  = run_ex && ins.acmd == AC_INC && q.addr == {ADDR_W{1'b1}};
        d.pend = run_ex && ins.rw == RW_RD && ins.cmp;
        adv    = 1'b0;
        dec    = 1'b0;
        case (ins.seq)
            SQ_LOOP_A: adv = a_ovf;
            SQ_BR_A: begin
                adv = a_ovf;
                dec = !a_ovf;
            end
            SQ_BR_D: begin
                adv = d_ovf;
                dec = !d_ovf;
            end
            SQ_LOOP_D: adv = d_ovf;
            default:   adv = 1'b1;
        endcase
        case (q.state)
            ST_IDLE, ST_DONE: begin
                if (accept) begin
                    d.state = ST_RUN;
                    d.ptr   = '0;
                    d.addr  = '0;
                end
            end
            ST_RUN: begin
                if (ins.halt) begin
                    d.state = ST_DRAIN;
                end else begin
                    case (ins.acmd)
                        AC_INC:  d.addr = q.addr + 1'b1;
                        AC_CLR:  d.addr = '0;
                        default: ;
                    endcase
                    if (adv) begin
                        if (q.ptr == LAST) d.state = ST_DRAIN;
                        else               d.ptr   = q.ptr + 1'b1;
                    end else if (dec && q.ptr != '0) begin
                        d.ptr = q.ptr - 1'b1;
                    end
                end
            end
            ST_DRAIN: d.state = ST_DONE;
            default:  d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign ram_addr  = q.addr;
    assign ram_wdata = data_q;
    assign ram_we    = run_ex && ins.rw == RW_WR;
    assign ram_re    = run_ex && ins.rw == RW_RD;
    assign done      = (q.state == ST_DONE);

endmodule

// File: rtl/mbist_engine_chk.sv
module mbist_engine_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              ram_we,
    input logic              ram_re,
    input logic              done,
    input logic [DATA_W-1:0] signature
);

    p_strobe_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_we && ram_re));

    p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ram_addr) |-> (ram_addr == ADDR_W'($past(ram_addr) + 1'b1) || ram_addr == '0));

    p_start_clears_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && done) |=> !done);

    p_drain_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (!$past(ram_we) && !$past(ram_re)));

    p_done_bus_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!ram_we && !ram_re));

    p_sig_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(done)) |-> $stable(signature));

endmodule

bind mbist_engine mbist_engine_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .ram_addr  (ram_addr),
    .ram_we    (ram_we),
    .ram_re    (ram_re),
    .done      (done),
    .signature (signature)
);

// File: tb/mbist_engine_tb.sv
`timescale 1ns/1ps
module mbist_engine_tb;

    localparam int DW = 8;
    localparam int AW = 4;
    localparam int NPROG = 5;

    function automatic logic [11:0] mk(input int sq, input int ac, input int dc,
                                       input int rw, input int cp, input int ht);
        return {ht[0], cp[0], rw[1:0], dc[2:0], ac[1:0], sq[2:0]};
    endfunction

    // five programs of eight words each
    localparam logic [11:0] PROG_TAB [0:39] = '{
        // 0: read-before-write conversion of zeros to ones (address branch-back)
        mk(1,1,1,2,0,0), mk(0,0,2,1,1,0), mk(2,1,2,2,0,0), mk(1,1,0,1,1,0),
        mk(0,0,0,0,0,1), mk(0,0,0,0,0,1), mk(0,0,0,0,0,1), mk(0,0,0,0,0,1),
        // 1: zero blanket write then read
        mk(1,1,1,2,0,0), mk(1,1,0,1,1,0), mk(0,0,0,0,0,1), mk(0,0,0,0,0,1),
        mk(0,0,0,0,0,1), mk(0,0,0,0,0,1), mk(0,0,0,0,0,1), mk(0,0,0,0,0,1),
        // 2: walking one written until data overflow, then read all
        mk(0,2,5,0,0,0), mk(4,1,3,2,0,0), mk(0,2,0,0,0,0), mk(1,1,0,1,1,0),
        mk(0,0,0,0,0,1), mk(0,0,0,0,0,1), mk(0,0,0,0,0,1), mk(0,0,0,0,0,1),
        // 3: rotate-invert/rotate loop on data overflow, ends past last entry
        mk(0,2,5,0,0,0), mk(0,1,4,2,0,0), mk(3,0,3,1,1,0), mk(0,2,1,0,0,0),
        mk(1,1,0,1,1,0), mk(0,0,2,2,0,0), mk(0,1,0,1,1,0), mk(0,1,3,1,1,0),
        // 4: branch-back held at entry 0, then halt before more writes
        mk(2,1,2,2,0,0), mk(0,0,0,0,0,1), mk(0,1,1,2,0,0), mk(0,1,1,2,0,0),
        mk(0,1,1,2,0,0), mk(0,1,1,2,0,0), mk(0,1,1,2,0,0), mk(0,1,1,2,0,0)
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prog_we = 1'b0;
    logic [2:0]    prog_idx = '0;
    logic [11:0]   prog_word = '0;
    logic          start = 1'b0;
    logic [AW-1:0] ram_addr;
    logic [DW-1:0] ram_wdata;
    logic          ram_we, ram_re;
    logic [DW-1:0] ram_rdata = '0;
    logic          done;
    logic [DW-1:0] signature;
    logic          fill_req = 1'b0;
    logic [DW-1:0] mem [0:(1<<AW)-1];

    int nchk = 0;
    int nfail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    mbist_engine u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_we   (prog_we),
        .prog_idx  (prog_idx),
        .prog_word (prog_word),
        .start     (start),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .ram_we    (ram_we),
        .ram_re    (ram_re),
        .ram_rdata (ram_rdata),
        .done      (done),
        .signature (signature)
    );

    function automatic logic [DW-1:0] fill_val(input int i);
        return DW'(i * 37 + 5);
    endfunction

    // bench RAM: one-cycle registered read
    always @(posedge clk) begin
        if (fill_req) begin
            for (int i = 0; i < (1 << AW); i++) mem[i] <= fill_val(i);
        end else if (ram_we) begin
            mem[ram_addr] <= ram_wdata;
        end
        if (ram_re) ram_rdata <= mem[ram_addr];
    end

    function automatic logic [DW-1:0] sig_step(input logic [DW-1:0] s, input logic [DW-1:0] v);
        return {s[DW-2:0], 1'b0} ^ (s[DW-1] ? 8'h1D : 8'h00) ^ v;
    endfunction

    // interpreter built from the requirement encodings
    task automatic model_run(input int p, output logic [DW-1:0] sig, output int steps);
        logic [DW-1:0] mm [0:(1<<AW)-1];
        logic [11:0]   w;
        int ptr, rot;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        bit fin, aovf, dovf, adv, dec;
        for (int i = 0; i < (1 << AW); i++) mm[i] = fill_val(i);
        ptr = 0; rot = 0; addr = '0; data = '0; sig = '0; steps = 0; fin = 0;
        while (!fin && steps < 4000) begin
            w = PROG_TAB[p*8 + ptr];
            steps++;
            if (w[11]) begin
                fin = 1;
            end else begin
                if (w[9:8] == 2'd2) mm[addr] = data;
                else if (w[9:8] == 2'd1 && w[10]) sig = sig_step(sig, mm[addr]);
                aovf = (w[4:3] == 2'd1) && (addr == '1);
                if (w[4:3] == 2'd1) addr = addr + 1'b1;
                else if (w[4:3] == 2'd2) addr = '0;
                dovf = 0;
                case (w[7:5])
                    3'd1: begin data = '0; rot = 0; end
                    3'd2: data = ~data;
                    3'd3, 3'd4: begin
                        dovf = (rot == DW - 1);
                        rot = (rot + 1) % DW;
                        data = {data[DW-2:0], data[DW-1]};
                        if (w[7:5] == 3'd4) data = ~data;
                    end
                    3'd5: begin data = 1; rot = 0; end
                    default: ;
                endcase
                adv = 0; dec = 0;
                case (w[2:0])
                    3'd1: adv = aovf;
                    3'd2: begin adv = aovf; dec = !aovf; end
                    3'd3: begin adv = dovf; dec = !dovf; end
                    3'd4: adv = dovf;
                    default: adv = 1;
                endcase
                if (adv) begin
                    if (ptr == 7) fin = 1;
                    else ptr++;
                end else if (dec && ptr != 0) begin
                    ptr--;
                end
            end
        end
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic load_and_run(input int p, output int cyc);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            prog_we = 1'b1;
            prog_idx = 3'(i);
            prog_word = PROG_TAB[p*8 + i];
        end
        @(negedge clk);
        prog_we = 1'b0;
        fill_req = 1'b1;
        @(negedge clk);
        fill_req = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            #1;
            cyc++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] esig;
        int esteps, cyc;
        repeat (3) @(negedge clk);
        // reset state
        chk("R2 reset done", 32'(done), 32'd0);
        chk("R3 reset strobes", {30'd0, ram_we, ram_re}, 32'd0);
        chk("R9 reset signature", 32'(signature), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 idle no done", 32'(done), 32'd0);

        // table walk: each program loaded through the R1 port
        for (int p = 0; p < NPROG; p++) begin
            model_run(p, esig, esteps);
            load_and_run(p, cyc);
            chk($sformatf("R1 R9 program %0d signature", p), 32'(signature), 32'(esig));
            chk($sformatf("R4 R6 R7 R8 program %0d run length", p), 32'(cyc), 32'(esteps + 1));
            if (p == 1) chk("R2 signature cleared by restart", 32'(signature), 32'd0);
            if (p == 2) begin
                for (int i = 0; i < DW; i++)
                    chk($sformatf("R5 walking one at %0d", i), 32'(mem[i]), 32'(1 << i));
                chk("R5 untouched above walk", 32'(mem[DW]), 32'(fill_val(DW)));
            end
            if (p == 4) begin
                chk("R7 entry0 held, odd word inverted", 32'(mem[1]), 32'hFF);
                chk("R8 halt stopped later writes", 32'(mem[2]), 32'h00);
                chk("R8 halt stopped last word", 32'(mem[15]), 32'hFF);
            end
        end

        // done persistence
        repeat (4) @(negedge clk);
        chk("R10 done held", 32'(done), 32'd1);
        chk("R10 bus idle while done", {30'd0, ram_we, ram_re}, 32'd0);
        model_run(NPROG - 1, esig, esteps);
        chk("R10 signature held", 32'(signature), 32'(esig));

        // a start pulse at done drops done the next cycle
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 done cleared by start", 32'(done), 32'd0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule